// File: doc/BRIEF.md
# Guarded Byte Memory Write Controller

This block sits between a processor's simple register bus and a small byte-wide memory array that is modelled as nonvolatile. Software sees four 8-bit registers: a memory address, a data byte, a control word and an unlock key. Reading a byte takes one control write, and the result can be read on the next bus access. Writing a byte is guarded. Software must first set a write-enable bit. It must then write the two key bytes 55h and AAh, back to back, to the key register. Only after that may it set the write-start bit.

A started write occupies the array for a fixed number of clock cycles, set by a parameter. During that time the write-start bit reads as one, and the address and data registers are frozen. When the write ends, the byte is stored and the start bit drops. A sticky completion flag is also set. Through an interrupt-enable bit, this flag drives a level interrupt line. Only software can clear the flag.

Register offsets on `bus_addr`: 0 = address, 1 = data, 2 = control, 3 = unlock key. Control bits: 0 = read strobe (always reads 0), 1 = write busy / start, 2 = write enable, 3 = completion flag, 4 = interrupt enable, 7 = region select (1 selects a region this block does not serve), 5 and 6 read 0. A bus access is one cycle with `bus_valid` high. Read data is registered and appears on `bus_rdata` one cycle after the read access, and it holds until the next read.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: After reset, every register reads 00h, `bus_rdata` is 00h and `irq` is low.
- R2: If the address register is written and then control is written with bit 0 set and bit 7 clear, the next read of the data register returns the byte stored at that address.
- R3: A control write with bits 0 and 7 both set leaves the data register unchanged.
- R4: The data register keeps its value until another read strobe or a software write to it, and a software write is read back unchanged.
- R5: A write starts (control bit 1 reads 1 on the following access) only on a control write with bit 1 set that directly follows 55h and then AAh written to offset 3. The key sequence is consumed by each attempt, so it is needed again for every byte.
- R6: A wrong key value, or any other bus access between the steps, returns the unlock tracking to its initial state, and the next start attempt does nothing.
- R7: A start attempt does nothing unless control bit 2 was already 1 before that bus write. Setting bits 1 and 2 in the same write starts nothing.
- R8: A started write keeps control bit 1 high for exactly `WR_CYCLES` clock cycles. It then stores the data byte at the latched address, clears bit 1 and sets bit 3.
- R9: Hardware never changes control bit 2. Clearing it during a write does not abort that write.
- R10: Control bit 3 is cleared only by a control write with bit 3 at 0. Writing 1 to it neither sets it nor clears it.
- R11: `irq` equals control bit 3 AND control bit 4.
- R12: Offset 3 always reads 00h.
- R13: While a write is busy, address and data writes, read strobes and new start attempts are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | One-cycle bus access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level completion interrupt |

## Verification
The assertions assume that the bus holds a single access per cycle and that `bus_valid` is low throughout reset. They also assume that memory locations are written before they are read, because the array has no reset. The stimulus drives each access for exactly one clock, starting from a falling edge. It writes every location once before any read-back. It reads the interrupt and busy state only through the ports, so each expected value follows from the register map.

// File: rtl/nvm_guard_pkg.sv
`timescale 1ns/1ps
package nvm_guard_pkg;
  localparam int DW = 8;

  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_KEY  = 2'd3;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WREN = 2;
  localparam int CB_DONE = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_MSEL = 7;

  localparam logic [DW-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DW-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_HALF  = 2'd1,
    UNL_ARMED = 2'd2
  } unl_state_e;
endpackage

// File: rtl/nvm_unlock_seq.sv
`timescale 1ns/1ps
module nvm_unlock_seq
  import nvm_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic          armed
);
  unl_state_e st_q;
  logic       key_wr;

  assign key_wr = acc && wr && (addr == REG_KEY);

  // Every access moves the tracker; only the exact next step advances it.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= UNL_IDLE;
    end else if (acc) begin
      if (key_wr && st_q == UNL_IDLE && wdata == KEY_FIRST)
        st_q <= UNL_HALF;
      else if (key_wr && st_q == UNL_HALF && wdata == KEY_SECOND)
        st_q <= UNL_ARMED;
      else
        st_q <= UNL_IDLE;
    end
  end

  assign armed = (st_q == UNL_ARMED);
endmodule

// File: rtl/nvm_byte_array.sv
`timescale 1ns/1ps
module nvm_byte_array #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_write_timer.sv
`timescale 1ns/1ps
module nvm_write_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= CW'(CYCLES - 1);
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign fire = busy && (cnt_q == '0);
endmodule

// File: rtl/nvm_guard_ctrl.sv
`timescale 1ns/1ps
module nvm_guard_ctrl
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int WR_CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;
  logic [DW-1:0]     mem_q;
  logic              wren_q, ien_q, msel_q, done_q, rd_pend_q;
  logic              busy, fire, armed;
  logic              wr_addr, wr_data, wr_ctrl, rd_acc;
  logic              start_req, rd_strobe;
  logic [DW-1:0]     data_view, ctrl_view;

  assign wr_addr = bus_valid && bus_write && (bus_addr == REG_ADDR);
  assign wr_data = bus_valid && bus_write && (bus_addr == REG_DATA);
  assign wr_ctrl = bus_valid && bus_write && (bus_addr == REG_CTRL);
  assign rd_acc  = bus_valid && !bus_write;

  assign start_req = wr_ctrl && bus_wdata[CB_WR] && wren_q && armed && !busy;
  assign rd_strobe = wr_ctrl && bus_wdata[CB_RD] && !bus_wdata[CB_MSEL] && !busy;

  nvm_unlock_seq u_unlock (
    .clk   (clk),
    .rst   (rst),
    .acc   (bus_valid),
    .wr    (bus_write),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .armed (armed)
  );

  nvm_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start_req),
    .busy  (busy),
    .fire  (fire)
  );

  nvm_byte_array #(.AW(ADDR_W), .W(DW)) u_array (
    .clk   (clk),
    .we    (fire),
    .waddr (addr_q),
    .wdata (data_q),
    .re    (rd_strobe),
    .raddr (addr_q),
    .rdata (mem_q)
  );

  // Address and data are frozen for the whole write.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_strobe;
      if (wr_addr && !busy) addr_q <= bus_wdata[ADDR_W-1:0];
      if (wr_data && !busy)  data_q <= bus_wdata;
      else if (rd_pend_q)    data_q <= mem_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wren_q <= 1'b0;
      ien_q  <= 1'b0;
      msel_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        wren_q <= bus_wdata[CB_WREN];
        ien_q  <= bus_wdata[CB_IEN];
        msel_q <= bus_wdata[CB_MSEL];
      end
      if (fire)                                done_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_DONE]) done_q <= 1'b0;
    end
  end

  // A read issued right after the strobe sees the array output directly.
  assign data_view = rd_pend_q ? mem_q : data_q;

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_WR]   = busy;
    ctrl_view[CB_WREN] = wren_q;
    ctrl_view[CB_DONE] = done_q;
    ctrl_view[CB_IEN]  = ien_q;
    ctrl_view[CB_MSEL] = msel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      case (bus_addr)
        REG_ADDR: bus_rdata <= DW'(addr_q);
        REG_DATA: bus_rdata <= data_view;
        REG_CTRL: bus_rdata <= ctrl_view;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq = done_q & ien_q;
endmodule

// File: rtl/nvm_guard_ctrl_chk.sv
`timescale 1ns/1ps
module nvm_guard_ctrl_chk #(
  parameter int AW        = 6,
  parameter int WR_CYCLES = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [1:0]    bus_addr,
  input logic          wd_start,
  input logic          wd_done,
  input logic [7:0]    bus_rdata,
  input logic          irq,
  input logic          busy,
  input logic          done_q,
  input logic          wren_q,
  input logic [AW-1:0] addr_q
);
  int  run_cnt;
  logic ctrl_wr;

  assign ctrl_wr = bus_valid && bus_write && (bus_addr == 2'd2);

  always_ff @(posedge clk) begin
    if (rst)       run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else           run_cnt <= 0;
  end

  AST_START_FROM_CTRL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctrl_wr && wd_start)); // R5
  AST_START_NEEDS_PRIOR_WREN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wren_q)); // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_cnt == WR_CYCLES); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done_q); // R8
  AST_WREN_HELD: assert property (@(posedge clk) disable iff (rst)
    wren_q && !ctrl_wr |=> wren_q); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_q && !(ctrl_wr && !wd_done) |=> done_q); // R10
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_q); // R11
  AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_valid && !bus_write && bus_addr == 2'd3 |=> bus_rdata == 8'h00); // R12
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(addr_q)); // R13
endmodule

bind nvm_guard_ctrl nvm_guard_ctrl_chk #(.AW(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .wd_start  (bus_wdata[1]),
  .wd_done   (bus_wdata[3]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .busy      (busy),
  .done_q    (done_q),
  .wren_q    (wren_q),
  .addr_q    (addr_q)
);

// File: tb/test_nvm_guard_ctrl.sv
`timescale 1ns/1ps
module test_nvm_guard_ctrl;
  localparam int AW  = 6;
  localparam int WRC = 12;
  localparam int NV  = 6;
  localparam logic [1:0] A_ADDR = 2'd0, A_DATA = 2'd1, A_CTRL = 2'd2, A_KEY = 2'd3;

  // {address, byte}
  localparam logic [13:0] VEC [NV] = '{
    {6'd10, 8'h5A}, {6'd20, 8'hC3}, {6'd0, 8'h01},
    {6'd63, 8'hFE}, {6'd31, 8'h80}, {6'd1, 8'h7F}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_valid = 1'b0;
  logic       bus_write = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_mem [64];

  always #2.5 clk = ~clk;

  nvm_guard_ctrl #(.ADDR_W(AW), .WR_CYCLES(WRC)) i_nvm_guard_ctrl (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic unlock_start();
    bus_wr(A_KEY, 8'h55);
    bus_wr(A_KEY, 8'hAA);
    bus_wr(A_CTRL, 8'h06);
  endtask

  task automatic start_write(input logic [5:0] a, input logic [7:0] d);
    bus_wr(A_ADDR, {2'b00, a});
    bus_wr(A_DATA, d);
    bus_wr(A_CTRL, 8'h04);
    unlock_start();
  endtask

  task automatic poll_busy(output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      bus_rd(A_CTRL, v);
      if (!v[1]) break;
      n++;
    end
  endtask

  task automatic read_mem(input logic [5:0] a, output logic [7:0] v);
    bus_wr(A_ADDR, {2'b00, a});
    bus_wr(A_CTRL, 8'h05);
    bus_rd(A_DATA, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 irq", irq, 0);
    for (int r = 0; r < 4; r++) begin
      bus_rd(2'(r), v);
      check("R1 reg", v, 0);
    end

    // Table walk: guarded write, timing, flag, read-back
    for (int i = 0; i < NV; i++) begin
      start_write(VEC[i][13:8], VEC[i][7:0]);
      exp_mem[VEC[i][13:8]] = VEC[i][7:0];
      poll_busy(n);
      check("R8 busy length", n, WRC);
      bus_rd(A_CTRL, v);
      check("R8 R9 ctrl after write", v, 8'h0C);
      check("R11 irq masked", irq, 0);
      bus_wr(A_CTRL, 8'h04);
      bus_rd(A_CTRL, v);
      check("R10 flag cleared", v, 8'h04);
      read_mem(VEC[i][13:8], v);
      check("R2 read back", v, VEC[i][7:0]);
    end

    // R5: sequence is needed again for every byte
    bus_wr(A_DATA, 8'h11);
    bus_wr(A_CTRL, 8'h06);
    bus_rd(A_CTRL, v);
    check("R5 no restart without key", v, 8'h04);

    // R6: wrong key value
    bus_wr(A_ADDR, 8'd10);
    bus_wr(A_DATA, 8'h77);
    bus_wr(A_KEY, 8'h55);
    bus_wr(A_KEY, 8'h12);
    bus_wr(A_KEY, 8'hAA);
    bus_wr(A_CTRL, 8'h06);
    bus_rd(A_CTRL, v);
    check("R6 wrong key", v, 8'h04);
    // R6: intervening read
    bus_wr(A_KEY, 8'h55);
    bus_rd(A_ADDR, v);
    bus_wr(A_KEY, 8'hAA);
    bus_wr(A_CTRL, 8'h06);
    bus_rd(A_CTRL, v);
    check("R6 intervening access", v, 8'h04);
    // R6: intervening data write
    bus_wr(A_KEY, 8'h55);
    bus_wr(A_KEY, 8'hAA);
    bus_wr(A_DATA, 8'h77);
    bus_wr(A_CTRL, 8'h06);
    bus_rd(A_CTRL, v);
    check("R6 intervening write", v, 8'h04);
    read_mem(6'd10, v);
    check("R6 memory untouched", v, exp_mem[10]);

    // R7: enable and start in one write
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_DATA, 8'h77);
    unlock_start();
    bus_rd(A_CTRL, v);
    check("R7 same-write enable", v, 8'h04);

    // R12: key register reads zero
    bus_wr(A_KEY, 8'h55);
    bus_rd(A_KEY, v);
    check("R12 key reads 0", v, 0);

    // R3: region-select read ignored
    read_mem(6'd20, v);
    bus_wr(A_ADDR, 8'd63);
    bus_wr(A_CTRL, 8'h85);
    bus_rd(A_DATA, v);
    check("R3 select read ignored", v, exp_mem[20]);
    bus_wr(A_CTRL, 8'h04);

    // R4: data register holds, software write visible
    bus_wr(A_DATA, 8'h3C);
    bus_rd(A_DATA, v);
    check("R4 sw write", v, 8'h3C);
    repeat (5) @(negedge clk);
    bus_rd(A_DATA, v);
    check("R4 held", v, 8'h3C);

    // R9 R13: clear enable mid-write, try to move address/data, strobe a read
    start_write(6'd20, 8'hE1);
    exp_mem[20] = 8'hE1;
    bus_wr(A_CTRL, 8'h00);
    bus_wr(A_ADDR, 8'd30);
    bus_wr(A_DATA, 8'h99);
    bus_wr(A_CTRL, 8'h01);
    poll_busy(n);
    check("R9 write not aborted", n, WRC - 4);
    bus_rd(A_CTRL, v);
    check("R9 enable stays clear", v, 8'h08);
    bus_rd(A_ADDR, v);
    check("R13 addr frozen", v, 20);
    bus_rd(A_DATA, v);
    check("R13 data frozen", v, 8'hE1);
    read_mem(6'd20, v);
    check("R9 byte stored", v, 8'hE1);

    // R13: start attempt while busy does not extend the write
    start_write(6'd31, 8'h42);
    exp_mem[31] = 8'h42;
    unlock_start();
    poll_busy(n);
    check("R13 restart ignored", n, WRC - 3);
    read_mem(6'd31, v);
    check("R13 stored byte", v, 8'h42);

    // R10: flag semantics
    start_write(6'd1, 8'h24);
    poll_busy(n);
    bus_wr(A_CTRL, 8'h0C);
    bus_rd(A_CTRL, v);
    check("R10 writing 1 keeps", v, 8'h0C);
    // R11: irq gating
    bus_wr(A_CTRL, 8'h1C);
    check("R11 irq on", irq, 1);
    bus_wr(A_CTRL, 8'h0C);
    check("R11 irq masked", irq, 0);
    bus_wr(A_CTRL, 8'h14);
    check("R11 irq after clear", irq, 0);
    bus_rd(A_CTRL, v);
    check("R10 cleared by 0", v, 8'h14);
    bus_wr(A_CTRL, 8'h1C);
    bus_rd(A_CTRL, v);
    check("R10 writing 1 does not set", v, 8'h14);
    check("R11 irq stays low", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule